// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block is a management-bus master for PHY-style slaves, driven by a processor through two 32-bit registers. A control register sets the management-clock divisor and whether a preamble is sent, and shows a sticky completion flag. A data/command register takes a command word. Writing a word with its launch bit set starts one serial frame on the management clock and data lines.

The frame is made of an optional preamble of ones, a start pattern, an opcode, a 5-bit device address, a 5-bit register address, a turnaround and 16 data bits. All fields are sent MSB first. On a read, the master releases the data line from the turnaround onward. It samples the slave's 16 bits and places them in the low half of the data register. A compile-time parameter selects between two packings of the address fields in the command word.

Software sets the divisor, writes a command, polls the completion flag and then clears the control register. Clearing the control register while a frame is running abandons that frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Control register (select 0): bits [6:0] are the divisor and bit 7 is the preamble enable, both writable. Bit 8 is the completion flag, and a write to bit 8 has no effect on it. All other bits read 0. After reset, both registers read 0.
- R2: Data register (select 1), default layout: bits [15:0] hold the data, [22:18] the register address, [27:23] the device address, bit 28 requests a write, bit 29 requests a read (a read takes precedence) and bit 30 launches the frame. A write word that is accepted reads back unchanged after its frame ends.
- R3: While a frame runs, the clock output has a period of 2*(divisor+1) system clocks. When no frame runs, the clock output is low.
- R4: The frame is 32 ones if the preamble is enabled, then 01, then opcode 01 (write) or 10 (read), the device address, the register address, turnaround 10 and the 16 data bits, all MSB first. One bit is presented per clock rising edge, and the data line changes only after falling edges.
- R5: On a read, the output enable is low from the first turnaround bit to the end of the frame. The 16 bits sampled on the rising edges replace data register bits [15:0], MSB first. Bits [31:16] keep the value that was written.
- R6: An accepted launch clears the completion flag on the next cycle. The flag sets in the cycle the frame ends and stays set until the next accepted launch.
- R7: A data-register write made while a frame runs is ignored, whether or not it carries the launch bit. A launch written while the divisor is 0 starts no frame and leaves the completion flag unchanged.
- R8: Setting the divisor to 0 during a frame ends it: the clock and output enable drop low, no further clock edges follow, and the completion flag stays 0.
- R9: With the legacy layout parameter set, the register address is taken from bits [21:18] and zero-extended to 5 bits. The device address is taken from bits [27:22], and its low 5 bits are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 data/command |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check the following on every cycle:
- the clock stays low when no frame runs;
- the clock toggles only while the divider is enabled;
- read data changes only at a rising-edge sample;
- an accepted launch clears the flag and starts a frame;
- the flag rises only as a frame ends;
- a write during a frame leaves the data register alone.

Only the bench scenarios can show the rest:
- the exact bit sequence of each frame, compared against a reference model;
- the measured clock period;
- the read data the slave model returns;
- the legacy field packing;
- the effect of aborting a frame midway.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned FRAME_W  = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned START_B  = 30;
  localparam int unsigned RD_B     = 29;
  localparam int unsigned DONE_B   = 8;
  localparam int unsigned PRE_B    = 7;

  // Serial frame, MSB sent first
  function automatic logic [FRAME_W-1:0] build_frame(logic [REG_W-1:0] w, bit legacy);
    logic [4:0] dev, ra;
    if (legacy) begin
      dev = w[26:22];
      ra  = {1'b0, w[21:18]};
    end else begin
      dev = w[27:23];
      ra  = w[22:18];
    end
    return {2'b01, (w[RD_B] ? 2'b10 : 2'b01), dev, ra, 2'b10, w[DATA_W-1:0]};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = cnt_q >= div_i;
  assign rise_o = en_i && wrap && !mdc_q;
  assign fall_o = en_i && wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mdc_rise_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> $past(en_i));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pre_en_i,
  input  logic               rd_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               abort_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PW = $clog2(PRE_LEN + 1);
  localparam int unsigned IW = $clog2(FRAME_W);
  localparam logic [IW-1:0] LAST   = IW'(FRAME_W - 1);
  localparam logic [IW-1:0] TA_IDX = IW'(FRAME_W - DATA_W - 2);
  localparam logic [IW-1:0] D_IDX  = IW'(FRAME_W - DATA_W);

  logic               busy_q, rd_q;
  logic [PW-1:0]      pre_q;
  logic [IW-1:0]      idx_q;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               in_frame;

  assign in_frame  = busy_q && (pre_q == '0);
  assign done_o    = in_frame && fall_i && (idx_q == LAST) && !abort_i;
  assign mdio_o    = !in_frame || sh_q[FRAME_W-1];
  assign mdio_oe_o = busy_q && !(rd_q && in_frame && idx_q >= TA_IDX);
  assign busy_o    = busy_q;
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      pre_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      rdata_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      pre_q  <= pre_en_i ? PW'(PRE_LEN) : '0;
      idx_q  <= '0;
      sh_q   <= frame_i;
    end else if (busy_q) begin
      if (fall_i) begin
        if (pre_q != '0) pre_q <= pre_q - 1'b1;
        else if (idx_q == LAST) busy_q <= 1'b0;
        else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
        end
      end
      if (rise_i && rd_q && in_frame && idx_q >= D_IDX)
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
    end
  end

  assert_rdata_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_q) |-> $past(rise_i));
  assert_end_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(fall_i || abort_i));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned PRE_LEN = 32,
  parameter bit          LEGACY  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              pre_q, done_q;
  logic [REG_W-1:0]  data_q;
  logic              busy, done_pulse, rise, fall, start_acc, abort, div_en;
  logic [DATA_W-1:0] rdata;

  assign start_acc = reg_we_i && reg_sel_i && reg_wdata_i[START_B] && (div_q != '0) && !busy;
  assign abort     = busy && (div_q == '0);
  assign div_en    = busy && (div_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (reg_we_i && !reg_sel_i) begin
        div_q <= reg_wdata_i[DIV_W-1:0];
        pre_q <= reg_wdata_i[PRE_B];
      end
      if (reg_we_i && reg_sel_i && !busy) data_q <= reg_wdata_i;
      else if (done_pulse && data_q[RD_B]) data_q[DATA_W-1:0] <= rdata;
      if (start_acc) done_q <= 1'b0;
      else if (done_pulse) done_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) reg_rdata_o = data_q;
    else begin
      reg_rdata_o[DIV_W-1:0] = div_q;
      reg_rdata_o[PRE_B]     = pre_q;
      reg_rdata_o[DONE_B]    = done_q;
    end
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .en_i(div_en), .div_i(div_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk_i, .rst_ni,
    .start_i(start_acc), .pre_en_i(pre_q), .rd_i(reg_wdata_i[RD_B]),
    .frame_i(build_frame(reg_wdata_i, LEGACY)),
    .abort_i(abort), .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .done_o(done_pulse), .mdio_o, .mdio_oe_o, .rdata_o(rdata)
  );

  assert_idle_mdc_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  assert_start_clears_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> (!done_q && busy));
  assert_done_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(busy));
  assert_busy_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i && busy && !done_pulse) |=> $stable(data_q));
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_slave_model (
  input  logic        clk_i,
  input  logic        mdc_i,
  input  logic        mdo_i,
  input  logic        oe_i,
  input  logic [15:0] resp_i,
  input  int          pre_i,
  output logic        mdi_o
);
  logic prev = 1'b0;
  int rises = 0, cyc = 0, last_rise = 0, period = 0;
  logic bits [64];
  logic oes  [64];

  task automatic clear();
    rises = 0;
    period = 0;
  endtask

  initial mdi_o = 1'b1;

  always @(negedge clk_i) begin
    int j;
    cyc++;
    if (mdc_i && !prev) begin
      if (rises < 64) begin
        bits[rises] = mdo_i;
        oes[rises]  = oe_i;
      end
      period = cyc - last_rise;
      last_rise = cyc;
      rises++;
    end
    prev = mdc_i;
    j = rises - pre_i - 16;
    mdi_o = (j >= 0 && j < 16) ? resp_i[15-j] : 1'b1;
  end
endmodule

module mdio_mgmt_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_d, rdata_l;
  logic mdc_d, mdo_d, oe_d, mdi_d, mdc_l, mdo_l, oe_l, mdi_l;
  logic [15:0] resp = '0;
  int pre_bits = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_d), .mdc_o(mdc_d), .mdio_o(mdo_d), .mdio_oe_o(oe_d), .mdio_i(mdi_d));
  mdio_mgmt_master #(.LEGACY(1'b1)) uut_leg (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_l), .mdc_o(mdc_l), .mdio_o(mdo_l), .mdio_oe_o(oe_l), .mdio_i(mdi_l));

  mdio_slave_model sl_d (.clk_i(clk), .mdc_i(mdc_d), .mdo_i(mdo_d), .oe_i(oe_d),
    .resp_i(resp), .pre_i(pre_bits), .mdi_o(mdi_d));
  mdio_slave_model sl_l (.clk_i(clk), .mdc_i(mdc_l), .mdo_i(mdo_l), .oe_i(oe_l),
    .resp_i(resp), .pre_i(pre_bits), .mdi_o(mdi_l));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(logic [31:0] w, bit leg);
    logic [4:0] dev, ra;
    dev = leg ? w[26:22] : w[27:23];
    ra  = leg ? {1'b0, w[21:18]} : w[22:18];
    return {2'b01, w[29] ? 2'b10 : 2'b01, dev, ra, 2'b10, w[15:0]};
  endfunction

  task automatic wr(logic s, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic s, output logic [31:0] v);
    sel = s;
    #1 v = rdata_d;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(1'b0, v);
      if (v[8]) break;
    end
  endtask

  // compare captured bits with expected frame; returns mismatch count
  function automatic int frame_err(bit leg, logic [31:0] w, int pre);
    logic [31:0] f;
    int n;
    f = exp_frame(w, leg);
    n = 0;
    for (int i = 0; i < pre; i++) begin
      if ((leg ? sl_l.bits[i] : sl_d.bits[i]) !== 1'b1) n++;
      if ((leg ? sl_l.oes[i]  : sl_d.oes[i])  !== 1'b1) n++;
    end
    for (int i = 0; i < 32; i++) begin
      logic eoe, b, o;
      eoe = !(w[29] && i >= 14);
      b = leg ? sl_l.bits[pre+i] : sl_d.bits[pre+i];
      o = leg ? sl_l.oes[pre+i]  : sl_d.oes[pre+i];
      if (o !== eoe) n++;
      if (eoe && b !== f[31-i]) n++;
    end
    return n;
  endfunction

  task automatic txn(logic [31:0] w, bit pre, int div);
    logic [31:0] v;
    int nb;
    wr(1'b0, {24'd0, pre, 7'(div)});
    pre_bits = pre ? 32 : 0;
    resp = 16'($urandom);
    sl_d.clear(); sl_l.clear();
    wr(1'b1, w | 32'h4000_0000);
    rd(1'b0, v);
    check("R6 done cleared after launch", {31'd0, v[8]}, 32'd0);
    wait_done();
    rd(1'b0, v);
    check("R6 done set at end", {31'd0, v[8]}, 32'd1);
    nb = pre_bits + 32;
    check("R4 rising edge count", sl_d.rises, nb);
    check("R4 R2 frame bits default layout", frame_err(1'b0, w, pre_bits), 0);
    check("R9 frame bits legacy layout", frame_err(1'b1, w, pre_bits), 0);
    check("R3 clock period", sl_d.period, 2 * (div + 1));
    rd(1'b1, v);
    if (w[29]) check("R5 read data in data register", v, {w[31:16] | 16'h4000, resp});
    else check("R2 data register readback", v, w | 32'h4000_0000);
    wr(1'b0, 32'd0);
  endtask

  initial begin
    int c = 0;
    while (!finished) begin
      @(posedge clk);
      c++;
      if (c > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", c);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, w1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); check("R1 control reset", v, 32'd0);
    rd(1'b1, v); check("R1 data reset", v, 32'd0);
    check("R3 idle clock low", {31'd0, mdc_d}, 32'd0);

    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); check("R1 control fields, done not writable", v, 32'h0000_00FF);
    wr(1'b0, 32'd0);

    // directed: write with preamble, read without
    txn({1'b0, 1'b0, 1'b1, 5'h15, 5'h0A, 2'b00, 16'hA5C3}, 1'b1, 2);
    txn({1'b0, 1'b1, 1'b0, 5'h03, 5'h1F, 2'b01, 16'h0000}, 1'b0, 1);
    // R9 legacy: top device bit set and register bit 22 high
    txn({4'b0001, 6'b1_00101, 4'hD, 2'b10, 16'h1234}, 1'b0, 1);
    txn({4'b0010, 6'b0_11010, 4'h6, 2'b00, 16'hFFFF}, 1'b1, 1);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[31:30] = 2'b00;
      w[28] = ~w[29];
      txn(w, 1'($urandom), 1 + int'($urandom % 4));
    end

    // R7: launch while busy ignored
    wr(1'b0, 32'd1);
    pre_bits = 0;
    sl_d.clear(); sl_l.clear();
    w1 = 32'h5112_BEEF;
    wr(1'b1, w1);
    repeat (10) @(negedge clk);
    wr(1'b1, 32'h6F00_0000);
    wait_done();
    check("R7 frame unchanged by busy write", frame_err(1'b0, w1, 0), 0);
    rd(1'b1, v); check("R7 data register keeps first word", v, w1);

    // R7: launch with divisor zero ignored (done stays 1)
    wr(1'b0, 32'd0);
    sl_d.clear();
    wr(1'b1, 32'h5000_1111);
    repeat (100) @(negedge clk);
    check("R7 no frame with divisor 0", sl_d.rises, 0);
    rd(1'b0, v); check("R7 done unchanged with divisor 0", {31'd0, v[8]}, 32'd1);

    // R8: abort mid-frame
    wr(1'b0, 32'h0000_0082);
    sl_d.clear();
    wr(1'b1, 32'h5080_0000);
    repeat (40) @(negedge clk);
    wr(1'b0, 32'd0);
    repeat (5) @(negedge clk);
    check("R8 clock and enable low after abort", {30'd0, mdc_d, oe_d}, 32'd0);
    begin
      int r0;
      r0 = sl_d.rises;
      repeat (300) @(negedge clk);
      check("R8 no clock edges after abort", sl_d.rises, r0);
    end
    rd(1'b0, v); check("R8 done stays 0 after abort", {31'd0, v[8]}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule